// File: doc/BRIEF.md
# Bit-manipulation logic and rotate unit

This unit is one execution slot of an integer pipeline. Each cycle it may accept a 32-bit instruction word together with two register operand values. It decodes a small family of bit-manipulation operations: three bitwise logic operations in which the second operand is inverted or the result is inverted, full-width rotates by a register or immediate amount, and, on a 64-bit configuration, rotates of the low 32-bit word whose result is sign-extended. The result, a valid flag and an illegal-encoding flag appear on registered outputs one clock after the request.

The parameter `XLEN` picks the 32-bit or 64-bit behaviour. The rotate amount is always taken modulo `XLEN`, so only its low log2(XLEN) bits matter. Encodings outside the family, the word rotates on a 32-bit configuration, and 32-bit immediate rotates that set the sixth amount bit are all reported as illegal, with valid low and a zero result.

The block has no state machine. The only state is the output register stage, which has two named conditions: idle (no request in the previous cycle) and loaded (valid or illegal result present). Every cycle is a transition from the current request: no request leads to idle, and a request leads to loaded.

Top module: `bmu_top`

## Requirements
- R1: With opcode bits 6:0 = 0110011, bits 31:25 = 0100000 and bits 14:12 = 111, the result is op_a AND (NOT op_b).
- R2: With opcode 0110011, bits 31:25 = 0100000 and bits 14:12 = 110, the result is op_a OR (NOT op_b).
- R3: With opcode 0110011, bits 31:25 = 0100000 and bits 14:12 = 100, the result is NOT (op_a XOR op_b).
- R4: With opcode 0110011 and bits 31:25 = 0110000, bits 14:12 = 001 rotates op_a left and 101 rotates it right, by the low log2(XLEN) bits of op_b; the higher bits of op_b have no effect.
- R5: With opcode 0010011, bits 31:26 = 011000 and bits 14:12 = 101, op_a is rotated right by the amount in bits 20+log2(XLEN)-1 down to 20 of the instruction.
- R6: With XLEN = 32, the immediate rotate of R5 with instruction bit 25 set is illegal.
- R7: With XLEN = 64 and bits 31:25 = 0110000, opcode 0111011 with bits 14:12 = 001 (left) or 101 (right) rotates the low 32 bits of op_a by op_b[4:0], and opcode 0011011 with bits 14:12 = 101 rotates them right by instruction bits 24:20; bits 63:32 of the result are copies of result bit 31.
- R8: With XLEN = 32, the encodings of R7 are illegal.
- R9: Any other instruction word presented with in_valid gives res_illegal = 1, res_valid = 0 and res_data = 0.
- R10: Results appear one clock after in_valid; after reset, and one clock after a cycle with in_valid low, res_valid, res_illegal and res_data are all zero.
- R11: A rotate amount of zero returns the operand unchanged; the word rotates still sign-extend from bit 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A request is present this cycle |
| insn | input | 32 | Instruction word |
| op_a | input | XLEN | First register operand |
| op_b | input | XLEN | Second register operand |
| res_valid | output | 1 | Registered: result of a recognised operation |
| res_illegal | output | 1 | Registered: request had an illegal encoding |
| res_data | output | XLEN | Registered result, zero when not valid |

## Verification
The assertions assume that the instruction word and operands are known values whenever in_valid is high, and that reset is applied before the first request. The stimulus drives every input at the falling edge from a fixed-seed random source, builds instruction words only from the field values of the requirements plus one deliberately foreign encoding, and forces the rotate amounts 0 and XLEN-1 as well as random ones. The 32-bit configuration is exercised by a second instance sharing the same inputs, so the reserved immediate case and the word rotates reach it with the same timing.

// File: rtl/bmu_pkg.sv
package bmu_pkg;

    typedef enum logic [3:0] {
        OP_NONE,
        OP_ANDN,
        OP_ORN,
        OP_XNOR,
        OP_ROL,
        OP_ROR,
        OP_RORI,
        OP_ROLW,
        OP_RORW,
        OP_RORIW
    } bmu_op_e;

    localparam logic [6:0] OPC_REG  = 7'b0110011;
    localparam logic [6:0] OPC_IMM  = 7'b0010011;
    localparam logic [6:0] OPC_REGW = 7'b0111011;
    localparam logic [6:0] OPC_IMMW = 7'b0011011;

    localparam logic [6:0] F7_INV = 7'b0100000;
    localparam logic [6:0] F7_ROT = 7'b0110000;

    localparam logic [2:0] F3_ANDN = 3'b111;
    localparam logic [2:0] F3_ORN  = 3'b110;
    localparam logic [2:0] F3_XNOR = 3'b100;
    localparam logic [2:0] F3_LEFT = 3'b001;
    localparam logic [2:0] F3_RGHT = 3'b101;

endpackage

// File: rtl/bmu_decode.sv
module bmu_decode
    import bmu_pkg::*;
#(
    parameter int XLEN = 64,
    localparam int SHW = $clog2(XLEN)
) (
    input  logic [31:0]    insn,
    output bmu_op_e        op,
    output logic [SHW-1:0] imm_amt
);

    logic [6:0] opc;
    logic [6:0] f7;
    logic [2:0] f3;
    logic       unused_regs;

    assign opc = insn[6:0];
    assign f7  = insn[31:25];
    assign f3  = insn[14:12];
    assign imm_amt = insn[20 +: SHW];
    assign unused_regs = ^{insn[19:15], insn[11:7], insn[24:20]};

    always_comb begin
        op = OP_NONE;
        case (opc)
            OPC_REG: begin
                if (f7 == F7_INV) begin
                    case (f3)
                        F3_ANDN: op = OP_ANDN;
                        F3_ORN:  op = OP_ORN;
                        F3_XNOR: op = OP_XNOR;
                        default: op = OP_NONE;
                    endcase
                end else if (f7 == F7_ROT) begin
                    case (f3)
                        F3_LEFT: op = OP_ROL;
                        F3_RGHT: op = OP_ROR;
                        default: op = OP_NONE;
                    endcase
                end
            end
            OPC_IMM: begin
                if (insn[31:26] == F7_ROT[6:1] && f3 == F3_RGHT
                    && (XLEN == 64 || !insn[25]))
                    op = OP_RORI;
            end
            OPC_REGW: begin
                if (XLEN == 64 && f7 == F7_ROT) begin
                    case (f3)
                        F3_LEFT: op = OP_ROLW;
                        F3_RGHT: op = OP_RORW;
                        default: op = OP_NONE;
                    endcase
                end
            end
            OPC_IMMW: begin
                if (XLEN == 64 && f7 == F7_ROT && f3 == F3_RGHT)
                    op = OP_RORIW;
            end
            default: op = OP_NONE;
        endcase
    end

endmodule

// File: rtl/bmu_logic.sv
module bmu_logic
    import bmu_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  bmu_op_e         op,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic [XLEN-1:0] y
);

    always_comb begin
        case (op)
            OP_ANDN: y = a & ~b;
            OP_ORN:  y = a | ~b;
            OP_XNOR: y = ~(a ^ b);
            default: y = '0;
        endcase
    end

endmodule

// File: rtl/bmu_rotate.sv
module bmu_rotate
    import bmu_pkg::*;
#(
    parameter int XLEN = 64,
    localparam int SHW = $clog2(XLEN)
) (
    input  bmu_op_e         op,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  logic [SHW-1:0]  imm_amt,
    output logic [XLEN-1:0] y
);

    logic [SHW-1:0]    amt;
    logic [2*XLEN-1:0] dbl;
    logic [2*XLEN-1:0] shr;
    logic [2*XLEN-1:0] shl;
    logic [XLEN-1:0]   word_y;
    logic              unused_b;

    assign amt = (op == OP_RORI || op == OP_RORIW) ? imm_amt : b[SHW-1:0];
    assign dbl = {a, a};
    assign shr = dbl >> amt;
    assign shl = dbl << amt;
    assign unused_b = ^b[XLEN-1:SHW];

    generate
        if (XLEN > 32) begin : g_word
            logic [63:0] wdbl;
            logic [63:0] wshr;
            logic [63:0] wshl;
            logic [31:0] wres;
            assign wdbl = {a[31:0], a[31:0]};
            assign wshr = wdbl >> amt[4:0];
            assign wshl = wdbl << amt[4:0];
            assign wres = (op == OP_ROLW) ? wshl[63:32] : wshr[31:0];
            assign word_y = {{(XLEN-32){wres[31]}}, wres};
        end else begin : g_noword
            assign word_y = '0;
        end
    endgenerate

    always_comb begin
        case (op)
            OP_ROL:                    y = shl[2*XLEN-1:XLEN];
            OP_ROR, OP_RORI:           y = shr[XLEN-1:0];
            OP_ROLW, OP_RORW, OP_RORIW: y = word_y;
            default:                   y = '0;
        endcase
    end

endmodule

// File: rtl/bmu_top.sv
module bmu_top
    import bmu_pkg::*;
#(
    parameter int XLEN = 64,
    localparam int SHW = $clog2(XLEN)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [31:0]     insn,
    input  logic [XLEN-1:0] op_a,
    input  logic [XLEN-1:0] op_b,
    output logic            res_valid,
    output logic            res_illegal,
    output logic [XLEN-1:0] res_data
);

    bmu_op_e         op;
    logic [SHW-1:0]  imm_amt;
    logic [XLEN-1:0] logic_y;
    logic [XLEN-1:0] rot_y;
    logic [XLEN-1:0] next_data;
    logic            is_logic;
    logic            is_word;
    logic            word_q;

    bmu_decode #(.XLEN(XLEN)) i_decode (
        .insn    (insn),
        .op      (op),
        .imm_amt (imm_amt)
    );

    bmu_logic #(.XLEN(XLEN)) i_logic (
        .op (op),
        .a  (op_a),
        .b  (op_b),
        .y  (logic_y)
    );

    bmu_rotate #(.XLEN(XLEN)) i_rotate (
        .op      (op),
        .a       (op_a),
        .b       (op_b),
        .imm_amt (imm_amt),
        .y       (rot_y)
    );

    assign is_logic  = (op == OP_ANDN) || (op == OP_ORN) || (op == OP_XNOR);
    assign is_word   = (op == OP_ROLW) || (op == OP_RORW) || (op == OP_RORIW);
    assign next_data = is_logic ? logic_y : rot_y;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_valid   <= 1'b0;
            res_illegal <= 1'b0;
            res_data    <= '0;
            word_q      <= 1'b0;
        end else if (in_valid) begin
            res_valid   <= (op != OP_NONE);
            res_illegal <= (op == OP_NONE);
            res_data    <= (op != OP_NONE) ? next_data : '0;
            word_q      <= is_word;
        end else begin
            res_valid   <= 1'b0;
            res_illegal <= 1'b0;
            res_data    <= '0;
            word_q      <= 1'b0;
        end
    end

    // R9
    flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(res_valid && res_illegal));

    // R9
    illegal_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_illegal |-> (res_data == '0));

    // R10
    idle_after_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!res_valid && !res_illegal && res_data == '0));

    // R10
    request_answered_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (res_valid || res_illegal));

    generate
        if (XLEN > 32) begin : g_chk64
            // R7
            word_sext_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (res_valid && word_q) |->
                (res_data[XLEN-1:31] == '0 || res_data[XLEN-1:31] == '1));
        end else begin : g_chk32
            // R6
            rori_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && insn[6:0] == OPC_IMM && insn[14:12] == F3_RGHT
                 && insn[31:25] == 7'b0110001) |=> res_illegal);
            // R8
            word_reg_illegal_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (in_valid && insn[6:0] == OPC_REGW) |=> res_illegal);
        end
    endgenerate

endmodule

// File: tb/test_bmu_top.sv
module test_bmu_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] insn = '0;
    logic [63:0] op_a = '0;
    logic [63:0] op_b = '0;

    logic        v64, il64;
    logic [63:0] d64;
    logic        v32, il32;
    logic [31:0] d32;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    bmu_top #(.XLEN(64)) i_bmu_top (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .insn(insn),
        .op_a(op_a), .op_b(op_b),
        .res_valid(v64), .res_illegal(il64), .res_data(d64)
    );

    bmu_top #(.XLEN(32)) i_bmu_top_rv32 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .insn(insn),
        .op_a(op_a[31:0]), .op_b(op_b[31:0]),
        .res_valid(v32), .res_illegal(il32), .res_data(d32)
    );

    function automatic logic [63:0] rotr(input logic [63:0] a, input int s, input int w);
        logic [63:0] r = '0;
        for (int i = 0; i < w; i++) r[i] = a[(i + s) % w];
        return r;
    endfunction

    function automatic logic [63:0] sext32(input logic [63:0] x);
        return {{32{x[31]}}, x[31:0]};
    endfunction

    function automatic logic [31:0] rtype(input logic [6:0] f7, input logic [2:0] f3,
                                          input logic [6:0] opc);
        return {f7, 5'd2, 5'd1, f3, 5'd3, opc};
    endfunction

    function automatic logic [31:0] itype(input logic [6:0] hi, input logic [4:0] sh,
                                          input logic [6:0] opc);
        return {hi, sh, 5'd1, 3'b101, 5'd3, opc};
    endfunction

    task automatic step(input logic v, input logic [31:0] i,
                        input logic [63:0] a, input logic [63:0] b);
        in_valid = v; insn = i; op_a = a; op_b = b;
        @(negedge clk);
    endtask

    task automatic chk64(input string tag, input logic ev, input logic ei,
                         input logic [63:0] ed);
        checks++;
        if (v64 !== ev || il64 !== ei || d64 !== ed) begin
            errors++;
            $display("FAIL %s rv64: got v=%0b il=%0b d=%h expected v=%0b il=%0b d=%h",
                     tag, v64, il64, d64, ev, ei, ed);
        end
    endtask

    task automatic chk32(input string tag, input logic ev, input logic ei,
                         input logic [31:0] ed);
        checks++;
        if (v32 !== ev || il32 !== ei || d32 !== ed) begin
            errors++;
            $display("FAIL %s rv32: got v=%0b il=%0b d=%h expected v=%0b il=%0b d=%h",
                     tag, v32, il32, d32, ev, ei, ed);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [63:0] a, b, e;
        logic [31:0] ins;
        void'($urandom(32'h5eed_0042));
        repeat (3) @(negedge clk);
        // R10 reset state
        chk64("R10 reset", 1'b0, 1'b0, 64'h0);
        chk32("R10 reset", 1'b0, 1'b0, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        a = 64'hF0F0_1234_FFFF_0000; b = 64'h0FF0_00FF_0F0F_FFFF;
        step(1'b1, rtype(7'b0100000, 3'b111, 7'b0110011), a, b);
        chk64("R1 andn", 1'b1, 1'b0, a & ~b);
        chk32("R1 andn", 1'b1, 1'b0, a[31:0] & ~b[31:0]);
        step(1'b1, rtype(7'b0100000, 3'b110, 7'b0110011), a, b);
        chk64("R2 orn", 1'b1, 1'b0, a | ~b);
        step(1'b1, rtype(7'b0100000, 3'b100, 7'b0110011), a, b);
        chk64("R3 xnor", 1'b1, 1'b0, ~(a ^ b));

        a = 64'h8000_0000_0000_0001;
        // R4 left by 63 with upper op_b bits set (masked)
        step(1'b1, rtype(7'b0110000, 3'b001, 7'b0110011), a, 64'hFFFF_FFFF_FFFF_FF3F);
        chk64("R4 rol 63", 1'b1, 1'b0, rotr(a, 1, 64));
        chk32("R4 rol 31", 1'b1, 1'b0, rotr({32'h0, a[31:0]}, 1, 32));
        // R11 amount zero
        step(1'b1, rtype(7'b0110000, 3'b101, 7'b0110011), a, 64'h40);
        chk64("R11 ror 0", 1'b1, 1'b0, a);
        // R5 immediate rotate by 63 (bit 25 set)
        step(1'b1, itype(7'b0110001, 5'd31, 7'b0010011), a, 64'h0);
        chk64("R5 rori 63", 1'b1, 1'b0, rotr(a, 63, 64));
        chk32("R6 rori shamt5", 1'b0, 1'b1, 32'h0);
        step(1'b1, itype(7'b0110000, 5'd0, 7'b0010011), a, 64'h0);
        chk64("R5 rori 0", 1'b1, 1'b0, a);
        chk32("R11 rori 0", 1'b1, 1'b0, a[31:0]);

        a = 64'h1234_5678_8765_4321;
        step(1'b1, rtype(7'b0110000, 3'b101, 7'b0111011), a, 64'h20);
        chk64("R11 rorw 0 sext", 1'b1, 1'b0, sext32(a));
        chk32("R8 rorw", 1'b0, 1'b1, 32'h0);
        step(1'b1, itype(7'b0110000, 5'd31, 7'b0011011), a, 64'h0);
        chk64("R7 roriw 31", 1'b1, 1'b0, sext32(rotr(a, 31, 32)));
        chk32("R8 roriw", 1'b0, 1'b1, 32'h0);
        step(1'b1, rtype(7'b0110000, 3'b001, 7'b0111011), a, 64'h1);
        chk64("R7 rolw 1", 1'b1, 1'b0, sext32(rotr(a, 31, 32)));

        // R9 foreign encodings
        step(1'b1, rtype(7'b0000000, 3'b000, 7'b0110011), a, b);
        chk64("R9 add", 1'b0, 1'b1, 64'h0);
        chk32("R9 add", 1'b0, 1'b1, 32'h0);
        step(1'b1, rtype(7'b0100000, 3'b101, 7'b0110011), a, b);
        chk64("R9 f3 hole", 1'b0, 1'b1, 64'h0);
        // R10 idle
        step(1'b0, rtype(7'b0100000, 3'b111, 7'b0110011), a, b);
        chk64("R10 idle", 1'b0, 1'b0, 64'h0);
        chk32("R10 idle", 1'b0, 1'b0, 32'h0);

        for (int n = 0; n < 400; n++) begin
            int k, s;
            logic [31:0] e32;
            a = {$urandom, $urandom}; b = {$urandom, $urandom};
            k = $urandom % 8;
            s = (n % 4 == 0) ? 0 : (n % 4 == 1) ? 63 : int'($urandom % 64);
            b[5:0] = s[5:0];
            case (k)
                0: begin ins = rtype(7'b0100000, 3'b111, 7'b0110011); e = a & ~b; end
                1: begin ins = rtype(7'b0100000, 3'b110, 7'b0110011); e = a | ~b; end
                2: begin ins = rtype(7'b0100000, 3'b100, 7'b0110011); e = ~(a ^ b); end
                3: begin ins = rtype(7'b0110000, 3'b001, 7'b0110011); e = rotr(a, (64 - s) % 64, 64); end
                4: begin ins = rtype(7'b0110000, 3'b101, 7'b0110011); e = rotr(a, s, 64); end
                5: begin ins = itype({6'b011000, s[5]}, s[4:0], 7'b0010011); e = rotr(a, s, 64); end
                6: begin ins = rtype(7'b0110000, 3'b101, 7'b0111011); e = sext32(rotr(a, s % 32, 32)); end
                default: begin ins = itype(7'b0110000, s[4:0], 7'b0011011); e = sext32(rotr(a, s % 32, 32)); end
            endcase
            step(1'b1, ins, a, b);
            chk64($sformatf("R4 R5 R7 random op %0d amt %0d", k, s), 1'b1, 1'b0, e);
            case (k)
                0: e32 = a[31:0] & ~b[31:0];
                1: e32 = a[31:0] | ~b[31:0];
                2: e32 = ~(a[31:0] ^ b[31:0]);
                3: e32 = rotr({32'h0, a[31:0]}, (32 - s % 32) % 32, 32);
                4: e32 = rotr({32'h0, a[31:0]}, s % 32, 32);
                default: e32 = 32'h0;
            endcase
            if (k <= 4) chk32($sformatf("R1 R4 random op %0d", k), 1'b1, 1'b0, e32);
            else if (k == 5 && s[5]) chk32("R6 random", 1'b0, 1'b1, 32'h0);
            else if (k == 5) chk32("R5 random", 1'b1, 1'b0, rotr({32'h0, a[31:0]}, s, 32));
            else chk32("R8 random", 1'b0, 1'b1, 32'h0);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule